// File: doc/BRIEF.md
# Irregular-Sequence Step Counter

This block walks a 4-bit state through a fixed, non-consecutive cycle of ten values. While the count input is high it advances one step on every clock. The cycle is 0, 2, 5, 6, 7, 9, 10, 12, 13, 15, and from 15 it returns to 0. While the count input is low the state stays where it is. A one-cycle terminal flag marks the step that wraps from 15 back to 0, so a second stage can chain on it.

Inside, the state is held in a loadable modulo-16 binary register. A purely combinational next-state stage drives it. For each step this stage chooses between the register's increment path and a parallel load of the next value, and it uses the increment path wherever that path already produces the right successor. The six codes that are not in the cycle lead back to 0 on the next counting clock, so the block recovers from any corrupted or arbitrary starting value. The value applied by reset and by clear is a parameter. Its default is 0.

Top module: `seqc_top`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the state becomes `RESTART_VALUE` (default 0) at that edge, and `tc` is 0 in the following cycle.
- R2: With `rst_n` high, a high `clr` at a rising edge sets the state to `RESTART_VALUE` at that edge, whatever the value of `x`.
- R3: With `rst_n` high and `clr` low, a low `x` at a rising edge leaves the state unchanged, including in codes outside the cycle.
- R4: With `x` high and `clr` low, each rising edge moves the state to its successor in the cycle 0→2→5→6→7→9→10→12→13→15→0.
- R5: `tc` is combinational and is 1 only while the state is 15 and `x` is 1. In that case the next counting edge yields state 0.
- R6: From any code outside the cycle (1, 3, 4, 8, 11, 14), a rising edge with `x` high and `clr` low gives state 0.
- R7: The register advances by its binary increment path exactly when the successor equals the current value plus one modulo 16. All other changes of value, and every hold, use the parallel load path.
- R8: A non-default `RESTART_VALUE`, including a code outside the cycle, is applied by both reset and clear, and counting proceeds from it by R3, R4 and R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous clear to the restart value, active high |
| x | input | 1 | Count enable: 1 steps the cycle, 0 holds |
| state | output | 4 | Current counter value |
| tc | output | 1 | Terminal flag: state is 15 while counting |

## Verification
The hardest behaviour to observe is recovery from the six codes outside the cycle. Reset, clear and the cycle itself never lead into those codes, so no sequence on `clk`, `clr` and `x` can reach them. The bench therefore builds six extra instances, each with `RESTART_VALUE` set to one of the unused codes. It resets them, checks that they hold that code while `x` is low, and then checks that one counting edge takes each of them to 0 and the next edge takes it to 2. The increment-versus-load choice is not visible at the ports. It is checked by an assertion on the register's increment path, and the bench checks the resulting values at every step.

// File: rtl/seqc_pkg.sv
// Package seqc_pkg
// Shared width, register operation type and the fixed cycle definition for
// the irregular step counter. Assumes a 4-bit state; the cycle is constant.
package seqc_pkg;

    localparam int unsigned SEQ_W = 4;
    localparam logic [SEQ_W-1:0] SEQ_LAST = 4'd15;

    typedef logic [SEQ_W-1:0] seq_state_t;

    // Operation requested from the loadable binary register.
    typedef enum logic {
        OP_INC  = 1'b0,
        OP_LOAD = 1'b1
    } core_op_t;

    // Successor of a code in the cycle; codes outside it return 0.
    function automatic seq_state_t seq_next(input seq_state_t s);
        seq_state_t r;
        case (s)
            4'd0:    r = 4'd2;
            4'd2:    r = 4'd5;
            4'd5:    r = 4'd6;
            4'd6:    r = 4'd7;
            4'd7:    r = 4'd9;
            4'd9:    r = 4'd10;
            4'd10:   r = 4'd12;
            4'd12:   r = 4'd13;
            4'd13:   r = 4'd15;
            4'd15:   r = 4'd0;
            default: r = 4'd0;
        endcase
        return r;
    endfunction

    // True when a code is part of the cycle.
    function automatic logic seq_member(input seq_state_t s);
        logic m;
        case (s)
            4'd0, 4'd2, 4'd5, 4'd6, 4'd7,
            4'd9, 4'd10, 4'd12, 4'd13, 4'd15: m = 1'b1;
            default:                          m = 1'b0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/seqc_core.sv
// Module seqc_core
// Loadable modulo-2^W binary register. Reset or clear applies RESTART,
// otherwise it either loads din or increments with wrap-around.
// Assumes op and din are settled before each rising edge.
module seqc_core
    import seqc_pkg::*;
#(
    parameter int unsigned W = 4,
    parameter logic [W-1:0] RESTART = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  core_op_t     op,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    // State register: restart, parallel load or binary increment.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            q <= RESTART;
        end else if (op == OP_LOAD) begin
            q <= din;
        end else begin
            q <= q + ONE;
        end
    end

    // R2 / R8: clear applies the restart value.
    p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q == RESTART));

    // R7: the increment path adds exactly one, modulo 2^W.
    p_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && op == OP_INC) |=> (q == W'($past(q) + ONE)));

    // R7: the load path delivers the presented value.
    p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && op == OP_LOAD) |=> (q == $past(din)));

endmodule

// File: rtl/seqc_glue.sv
// Module seqc_glue
// Combinational next-state stage. Picks the increment path when the cycle
// successor is current+1 (mod 16), otherwise loads the successor; with the
// count input low it loads the current value back. Drives the terminal flag.
// Assumes cur comes straight from the register output.
module seqc_glue
    import seqc_pkg::*;
(
    input  seq_state_t cur,
    input  logic       x,
    output core_op_t   op,
    output seq_state_t din,
    output logic       tc
);

    seq_state_t succ;
    seq_state_t plus1;

    // Successor lookup and the value the increment path would produce.
    always_comb begin
        succ  = seq_next(cur);
        plus1 = SEQ_W'(cur + 4'd1);
    end

    // Operation select: hold by reload, else increment or jump.
    always_comb begin
        if (!x) begin
            op  = OP_LOAD;
            din = cur;
        end else if (succ == plus1) begin
            op  = OP_INC;
            din = succ;
        end else begin
            op  = OP_LOAD;
            din = succ;
        end
    end

    // Terminal flag: last code of the cycle while counting.
    always_comb begin
        tc = x && (cur == SEQ_LAST);
    end

endmodule

// File: rtl/seqc_top.sv
// Module seqc_top
// Irregular-sequence step counter: a loadable binary register driven by a
// combinational next-state stage. Assumes synchronous active-low reset and
// a synchronous active-high clear, both to RESTART_VALUE.
module seqc_top
    import seqc_pkg::*;
#(
    parameter logic [3:0] RESTART_VALUE = 4'd0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       x,
    output logic [3:0] state,
    output logic       tc
);

    core_op_t   op_w;
    seq_state_t din_w;
    seq_state_t q_w;

    seqc_glue u_glue (
        .cur (q_w),
        .x   (x),
        .op  (op_w),
        .din (din_w),
        .tc  (tc)
    );

    seqc_core #(
        .W       (SEQ_W),
        .RESTART (RESTART_VALUE)
    ) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .op    (op_w),
        .din   (din_w),
        .q     (q_w)
    );

    // Output mapping of the register value.
    always_comb begin
        state = q_w;
    end

    // R3: no count input, no change.
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !x) |=> $stable(state));

    // R4: counting follows the cycle.
    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && x && seq_member(state)) |=> (state == seq_next($past(state))));

    // R5: terminal flag is followed by the wrap to 0.
    p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tc && !clr) |=> (state == 4'd0));

    // R6: codes outside the cycle recover to 0.
    p_recover_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && x && !seq_member(state)) |=> (state == 4'd0));

endmodule

// File: tb/sim_seqc_top.sv
// Directed bench for seqc_top: one task per scenario.
module sim_seqc_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr = 1'b0;
    logic       x = 1'b0;
    logic       x1 = 1'b0;
    logic [3:0] state;
    logic       tc;
    logic [3:0] ss_state [6];
    logic       ss_tc    [6];

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    localparam logic [3:0] UNUSED [6] = '{4'd1, 4'd3, 4'd4, 4'd8, 4'd11, 4'd14};
    localparam logic [3:0] CYCLE [10] = '{4'd0, 4'd2, 4'd5, 4'd6, 4'd7,
                                          4'd9, 4'd10, 4'd12, 4'd13, 4'd15};

    always #2 clk = ~clk;

    seqc_top u0 (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .x     (x),
        .state (state),
        .tc    (tc)
    );

    for (genvar k = 0; k < 6; k++) begin : g_ss
        seqc_top #(.RESTART_VALUE(UNUSED[k])) u_ss (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (1'b0),
            .x     (x1),
            .state (ss_state[k]),
            .tc    (ss_tc[k])
        );
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // R1: reset state and flag.
    task automatic t_reset();
        rst_n = 1'b0; x = 1'b1; x1 = 1'b0;
        tick(); tick();
        x = 1'b0;
        #1;
        check("R1 state", state, 0);
        check("R1 tc", tc, 0);
        rst_n = 1'b1;
    endtask

    // R4, R5, R7: two full laps of the cycle, checking every step and flag.
    task automatic t_cycle();
        x = 1'b1;
        for (int lap = 0; lap < 2; lap++) begin
            for (int i = 0; i < 10; i++) begin
                #0;
                check("R5 tc", tc, (CYCLE[i] == 4'd15) ? 1 : 0);
                tick();
                check("R4/R7 step", state, CYCLE[(i + 1) % 10]);
            end
        end
        x = 1'b0;
    endtask

    // R3, R5: hold at several points, flag low while holding at 15.
    task automatic t_hold();
        x = 1'b1;
        tick(); tick(); tick();           // 0 -> 2 -> 5 -> 6
        x = 1'b0;
        tick(); tick();
        check("R3 hold at 6", state, 6);
        x = 1'b1;
        tick(); tick(); tick(); tick(); tick(); tick(); // 7 9 10 12 13 15
        x = 1'b0;
        #0;
        check("R5 tc low while holding", tc, 0);
        tick();
        check("R3 hold at 15", state, 15);
        x = 1'b1;
        #0;
        check("R5 tc high at 15", tc, 1);
        tick();
        check("R5 wrap to 0", state, 0);
        x = 1'b0;
    endtask

    // R2: clear wins over counting, from mid-cycle and from 15.
    task automatic t_clear();
        x = 1'b1;
        tick(); tick(); tick(); tick();   // 0 2 5 6 7
        check("R2 setup", state, 7);
        clr = 1'b1;
        tick();
        check("R2 clear while counting", state, 0);
        clr = 1'b0;
        for (int i = 0; i < 9; i++) tick();
        check("R2 setup at 15", state, 15);
        clr = 1'b1; x = 1'b0;
        tick();
        check("R2 clear while holding", state, 0);
        clr = 1'b0; x = 1'b1;
        tick();
        check("R4 restart after clear", state, 2);
        x = 1'b0;
    endtask

    // R6, R8, R3: instances starting in unused codes hold, then recover.
    task automatic t_recover();
        for (int k = 0; k < 6; k++)
            check("R8 restart value", ss_state[k], UNUSED[k]);
        x1 = 1'b0;
        tick();
        for (int k = 0; k < 6; k++)
            check("R3 hold in unused code", ss_state[k], UNUSED[k]);
        x1 = 1'b1;
        tick();
        for (int k = 0; k < 6; k++)
            check("R6 recover to 0", ss_state[k], 0);
        tick();
        for (int k = 0; k < 6; k++)
            check("R6 then 2", ss_state[k], 2);
        x1 = 1'b0;
    endtask

    initial begin
        #1;
        t_reset();
        t_recover();
        t_cycle();
        t_hold();
        t_clear();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule